// File: doc/BRIEF.md
# Configuration-Space Outbound Address Translator

This block sits between a host that issues configuration reads and writes, each aimed at a bus, device, function and register offset, and a downstream single-beat bus. It checks each access against a per-bus device limit. It sets up one shared outbound translation region: the request kind, the packed target identifier and the enable bit. It then forms the dword-aligned address for the access and performs one beat. Accesses to bus 0 go to a local register window. All other buses go to a window that takes the last 1 MB of a 16 MB aperture.

An access to a device the rules reject never reaches the downstream bus, and a read of one returns all ones. A downstream error response still completes to the host. Read data is then forced to all ones, and a write is simply lost.

The controller is a four-state machine:
- IDLE waits for a request.
- SETUP loads the region registers.
- ISSUE drives the downstream beat until it is acknowledged.
- DONE presents the response for one cycle.

Its transitions are:
- IDLE→SETUP on an accepted valid target.
- IDLE→DONE on an accepted rejected target.
- SETUP→ISSUE always.
- ISSUE→DONE on `dn_ack`.
- DONE→IDLE always.

Top module: `cfgx_xlate`

## Requirements
- R1: A request to bus 0 with device above 1, or to bus 1 with device above 0, is rejected. `dn_valid` stays low for it, the region registers keep their values, and `rsp_valid` rises in the cycle after acceptance with `rsp_rdata` = 0xFFFFFFFF.
- R2: For an accepted valid request, `rgn_ctrl1` becomes 4 when the bus is 0 or 1, and 5 for any higher bus. The value is in bits 4:0 and all other bits are zero.
- R3: For a valid request to a non-zero bus, `rgn_target` becomes bus in bits 31:24, device in bits 23:19, function in bits 18:16, and zero in bits 15:0. A bus-0 request leaves `rgn_target` unchanged.
- R4: `dn_addr` is the base plus the register offset with bits 1:0 cleared. The base is 0x01FFC000 for bus 0 and 0x01F00000 (aperture 0x01000000 + 16 MB − 1 MB) for other buses.
- R5: `rgn_ctrl2` has bit 31 set whenever the region has been programmed and all other bits zero. It is zero after reset.
- R6: When `dn_ack` arrives with `dn_err` high, the access still completes. A read then returns 0xFFFFFFFF.
- R7: A read acknowledged without error returns `dn_rdata` unchanged. A write drives `dn_write` high and `dn_wdata` equal to `req_wdata`, and its response carries 0xFFFFFFFF.
- R8: `dn_valid`, `dn_addr`, `dn_write` and `dn_wdata` hold steady from the first ISSUE cycle until `dn_ack`. `rsp_valid` is high for exactly one cycle per accepted request. `req_ready` is high only in IDLE.
- R9: For a valid request, the region registers are updated and `dn_valid` is high two cycles after acceptance. `rsp_valid` follows one cycle after the acknowledging cycle.
- R10: After reset, `req_ready` = 1, `rsp_valid` = 0, `dn_valid` = 0, and all region registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_off | input | OFF_W | Register byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 32 | Read result (all ones on reject, error or write) |
| dn_valid | output | 1 | Downstream beat request |
| dn_write | output | 1 | Downstream beat direction |
| dn_addr | output | 32 | Downstream byte address |
| dn_wdata | output | 32 | Downstream write data |
| dn_ack | input | 1 | Downstream beat completed |
| dn_err | input | 1 | Downstream error response, qualified by dn_ack |
| dn_rdata | input | 32 | Downstream read data, qualified by dn_ack |
| rgn_ctrl1 | output | 32 | Region control 1: request type code |
| rgn_ctrl2 | output | 32 | Region control 2: bit 31 enable |
| rgn_target | output | 32 | Region target identifier |

## Verification
The bench uses the default parameters: a 12-bit offset, the 16 MB aperture at 0x01000000 with its 1 MB window, and device limits of 1 on bus 0 and 0 on bus 1. The 12-bit offset puts extended offsets with set low bits within reach. The default device limits put both rejection rules and their boundary devices within reach, alongside the type-1 buses from 2 up to 255. Downstream acknowledge latencies of zero to three cycles exercise the hold rule in ISSUE and the zero-wait path.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_ISSUE = 2'd2,
        ST_DONE  = 2'd3
    } cfgx_state_e;

    localparam logic [4:0] KIND_TYPE0 = 5'd4;
    localparam logic [4:0] KIND_TYPE1 = 5'd5;

    typedef struct packed {
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
    } cfgx_bdf_t;

    function automatic logic [31:0] pack_target(input cfgx_bdf_t id);
        return {id.bus, id.dev, id.fn, 16'h0000};
    endfunction

endpackage

// File: rtl/cfgx_route.sv
module cfgx_route
    import cfgx_pkg::*;
#(
    parameter int          OFF_W         = 12,
    parameter logic [31:0] LOCAL_BASE    = 32'h01FF_C000,
    parameter logic [31:0] WIN_BASE      = 32'h01F0_0000,
    parameter int          BUS0_DEV_MAX  = 1,
    parameter int          BUS1_DEV_MAX  = 0,
    parameter int          TYPE1_MIN_BUS = 2
) (
    input  cfgx_bdf_t         id,
    input  logic [OFF_W-1:0]  off,
    output logic              ok,
    output logic [4:0]        kind,
    output logic [31:0]       target,
    output logic              use_target,
    output logic [31:0]       addr
);
    localparam int PAD_W = 32 - OFF_W;

    logic [31:0] off_aligned;

    always_comb begin
        ok = 1'b1;
        if (id.bus == 8'd0 && int'(id.dev) > BUS0_DEV_MAX) ok = 1'b0;
        if (id.bus == 8'd1 && int'(id.dev) > BUS1_DEV_MAX) ok = 1'b0;
    end

    assign kind        = (int'(id.bus) < TYPE1_MIN_BUS) ? KIND_TYPE0 : KIND_TYPE1;
    assign use_target  = (id.bus != 8'd0);
    assign target      = pack_target(id);
    assign off_aligned = {{PAD_W{1'b0}}, off[OFF_W-1:2], 2'b00};
    assign addr        = (use_target ? WIN_BASE : LOCAL_BASE) + off_aligned;

endmodule

// File: rtl/cfgx_region.sv
module cfgx_region (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic        load_target,
    input  logic [4:0]  kind_in,
    input  logic [31:0] target_in,
    output logic [31:0] ctrl1,
    output logic [31:0] ctrl2,
    output logic [31:0] target
);
    logic [4:0] kind_q;
    logic       en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= '0;
            en_q   <= 1'b0;
            target <= '0;
        end else if (load) begin
            kind_q <= kind_in;
            en_q   <= 1'b1;
            if (load_target) target <= target_in;
        end
    end

    assign ctrl1 = {27'd0, kind_q};
    assign ctrl2 = {en_q, 31'd0};

    assert_kind_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ctrl1 == 32'd4 || ctrl1 == 32'd5));

    assert_target_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !load_target) |=> $stable(target));

endmodule

// File: rtl/cfgx_xlate.sv
module cfgx_xlate
    import cfgx_pkg::*;
#(
    parameter int          OFF_W          = 12,
    parameter logic [31:0] LOCAL_BASE     = 32'h01FF_C000,
    parameter logic [31:0] APERTURE_BASE  = 32'h0100_0000,
    parameter logic [31:0] APERTURE_BYTES = 32'h0100_0000,
    parameter logic [31:0] WINDOW_BYTES   = 32'h0010_0000,
    parameter int          BUS0_DEV_MAX   = 1,
    parameter int          BUS1_DEV_MAX   = 0,
    parameter int          TYPE1_MIN_BUS  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [7:0]       req_bus,
    input  logic [4:0]       req_dev,
    input  logic [2:0]       req_fn,
    input  logic [OFF_W-1:0] req_off,
    input  logic [31:0]      req_wdata,
    output logic             rsp_valid,
    output logic [31:0]      rsp_rdata,
    output logic             dn_valid,
    output logic             dn_write,
    output logic [31:0]      dn_addr,
    output logic [31:0]      dn_wdata,
    input  logic             dn_ack,
    input  logic             dn_err,
    input  logic [31:0]      dn_rdata,
    output logic [31:0]      rgn_ctrl1,
    output logic [31:0]      rgn_ctrl2,
    output logic [31:0]      rgn_target
);
    localparam logic [31:0] WIN_BASE = APERTURE_BASE + APERTURE_BYTES - WINDOW_BYTES;

    cfgx_state_e state, state_nx;

    cfgx_bdf_t   id_in;
    logic        rt_ok, rt_use_tgt;
    logic [4:0]  rt_kind;
    logic [31:0] rt_target, rt_addr;

    logic        accept;
    logic        use_tgt_q, wr_q;
    logic [4:0]  kind_q;
    logic [31:0] target_q, addr_q, wdata_q, rdata_q;
    logic        region_load;

    assign id_in = '{bus: req_bus, dev: req_dev, fn: req_fn};

    cfgx_route #(
        .OFF_W(OFF_W), .LOCAL_BASE(LOCAL_BASE), .WIN_BASE(WIN_BASE),
        .BUS0_DEV_MAX(BUS0_DEV_MAX), .BUS1_DEV_MAX(BUS1_DEV_MAX),
        .TYPE1_MIN_BUS(TYPE1_MIN_BUS)
    ) u_route (
        .id(id_in), .off(req_off), .ok(rt_ok), .kind(rt_kind),
        .target(rt_target), .use_target(rt_use_tgt), .addr(rt_addr)
    );

    cfgx_region u_region (
        .clk(clk), .rst_n(rst_n), .load(region_load), .load_target(use_tgt_q),
        .kind_in(kind_q), .target_in(target_q),
        .ctrl1(rgn_ctrl1), .ctrl2(rgn_ctrl2), .target(rgn_target)
    );

    assign accept = req_valid && (state == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = rt_ok ? ST_SETUP : ST_DONE;
            ST_SETUP: state_nx = ST_ISSUE;
            ST_ISSUE: if (dn_ack) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // captured request and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            use_tgt_q <= 1'b0;
            wr_q      <= 1'b0;
            kind_q    <= '0;
            target_q  <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
            rdata_q   <= '1;
        end else begin
            if (accept) begin
                use_tgt_q <= rt_use_tgt;
                wr_q      <= req_write;
                kind_q    <= rt_kind;
                target_q  <= rt_target;
                addr_q    <= rt_addr;
                wdata_q   <= req_wdata;
                rdata_q   <= '1;
            end else if (state == ST_ISSUE && dn_ack && !dn_err && !wr_q) begin
                rdata_q   <= dn_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready   = 1'b0;
        rsp_valid   = 1'b0;
        dn_valid    = 1'b0;
        region_load = 1'b0;
        unique case (state)
            ST_IDLE:  req_ready   = 1'b1;
            ST_SETUP: region_load = 1'b1;
            ST_ISSUE: dn_valid    = 1'b1;
            ST_DONE:  rsp_valid   = 1'b1;
            default:  ;
        endcase
    end

    assign dn_write  = wr_q;
    assign dn_addr   = addr_q;
    assign dn_wdata  = wdata_q;
    assign rsp_rdata = rdata_q;

    assert_reject_no_beat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !rt_ok) |=> (rsp_valid && !dn_valid && rsp_rdata == 32'hFFFF_FFFF));

    assert_enabled_on_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> rgn_ctrl2[31]);

    assert_err_all_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_ack && dn_err) |=> (rsp_valid && rsp_rdata == 32'hFFFF_FFFF));

    assert_beat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ack) |=> (dn_valid && $stable(dn_addr) && $stable(dn_wdata) && $stable(dn_write)));

    assert_rsp_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_beat_after_setup_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_valid) |-> $past(rgn_ctrl2[31] || region_load));

endmodule

// File: tb/sim_cfgx_xlate.sv
module sim_cfgx_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_fn = '0;
    logic [11:0] req_off = '0;
    logic [31:0] req_wdata = '0;
    logic        dn_ack = 1'b0, dn_err = 1'b0;
    logic [31:0] dn_rdata = '0;
    logic        req_ready, rsp_valid, dn_valid, dn_write;
    logic [31:0] rsp_rdata, dn_addr, dn_wdata, rgn_ctrl1, rgn_ctrl2, rgn_target;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_ctrl1 = 0, m_ctrl2 = 0, m_tgt = 0;

    always #5 clk = ~clk;

    cfgx_xlate u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn),
        .req_off(req_off), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dn_valid(dn_valid), .dn_write(dn_write), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
        .dn_ack(dn_ack), .dn_err(dn_err), .dn_rdata(dn_rdata),
        .rgn_ctrl1(rgn_ctrl1), .rgn_ctrl2(rgn_ctrl2), .rgn_target(rgn_target)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic f_valid(input logic [7:0] b, input logic [4:0] d);
        if (b == 8'd0 && d > 5'd1) return 1'b0;
        if (b == 8'd1 && d > 5'd0) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [31:0] f_addr(input logic [7:0] b, input logic [11:0] o);
        logic [31:0] base;
        base = (b == 8'd0) ? 32'h01FF_C000 : 32'h01F0_0000;
        return base + {20'd0, o[11:2], 2'b00};
    endfunction

    task automatic run(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                       input logic [11:0] o, input logic wr, input logic [31:0] wd,
                       input int lat, input logic err, input logic [31:0] rd);
        logic [31:0] exp_rsp;
        @(negedge clk);
        chk(req_ready == 1'b1, "R8 ready in idle", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_write = wr; req_bus = b; req_dev = d; req_fn = f;
        req_off = o; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R8 not ready when busy", {31'd0, req_ready}, 32'd0);
        if (!f_valid(b, d)) begin
            chk(rsp_valid == 1'b1, "R1 reject rsp next cycle", {31'd0, rsp_valid}, 32'd1);
            chk(rsp_rdata == 32'hFFFF_FFFF, "R1 reject data", rsp_rdata, 32'hFFFF_FFFF);
            chk(dn_valid == 1'b0, "R1 reject no beat", {31'd0, dn_valid}, 32'd0);
            @(negedge clk);
            chk(rgn_target == m_tgt && rgn_ctrl1 == m_ctrl1 && rgn_ctrl2 == m_ctrl2,
                "R1 region untouched", rgn_target, m_tgt);
            chk(rsp_valid == 1'b0 && dn_valid == 1'b0, "R8 single rsp", {31'd0, rsp_valid}, 32'd0);
            return;
        end
        chk(dn_valid == 1'b0 && rsp_valid == 1'b0, "R9 setup cycle quiet", {31'd0, dn_valid}, 32'd0);
        m_ctrl1 = (b < 8'd2) ? 32'd4 : 32'd5;
        m_ctrl2 = 32'h8000_0000;
        if (b != 8'd0) m_tgt = {b, d, f, 16'h0};
        @(negedge clk);
        chk(dn_valid == 1'b1, "R9 beat two cycles after accept", {31'd0, dn_valid}, 32'd1);
        chk(rgn_ctrl1 == m_ctrl1, "R2 type code", rgn_ctrl1, m_ctrl1);
        chk(rgn_target == m_tgt, "R3 target", rgn_target, m_tgt);
        chk(rgn_ctrl2 == m_ctrl2, "R5 enable", rgn_ctrl2, m_ctrl2);
        chk(dn_addr == f_addr(b, o), "R4 address", dn_addr, f_addr(b, o));
        chk(dn_write == wr, "R7 direction", {31'd0, dn_write}, {31'd0, wr});
        if (wr) chk(dn_wdata == wd, "R7 write data", dn_wdata, wd);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk(dn_valid == 1'b1 && dn_addr == f_addr(b, o), "R8 beat held", dn_addr, f_addr(b, o));
        end
        dn_ack = 1'b1; dn_err = err; dn_rdata = rd;
        @(negedge clk);
        dn_ack = 1'b0; dn_err = 1'b0; dn_rdata = '0;
        exp_rsp = (wr || err) ? 32'hFFFF_FFFF : rd;
        chk(rsp_valid == 1'b1 && dn_valid == 1'b0, "R9 rsp after ack", {31'd0, rsp_valid}, 32'd1);
        chk(rsp_rdata == exp_rsp, err ? "R6 error data" : "R7 read data", rsp_rdata, exp_rsp);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8 single rsp", {31'd0, rsp_valid}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int unsigned seed_init;
        seed_init = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && dn_valid == 1'b0, "R10 reset outputs",
            {29'd0, req_ready, rsp_valid, dn_valid}, 32'h4);
        chk(rgn_ctrl1 == 0 && rgn_ctrl2 == 0 && rgn_target == 0, "R10 region zero", rgn_ctrl2, 32'd0);
        rst_n = 1'b1;
        // directed corners
        run(8'd0, 5'd2, 3'd0, 12'h000, 1'b0, 0, 0, 1'b0, 32'h1);        // R1 bus0 dev2
        run(8'd1, 5'd1, 3'd0, 12'h000, 1'b0, 0, 0, 1'b0, 32'h1);        // R1 bus1 dev1
        run(8'd0, 5'd1, 3'd7, 12'h013, 1'b0, 0, 0, 1'b0, 32'hCAFE0001); // bus0 local, target kept
        run(8'd1, 5'd0, 3'd5, 12'hFFF, 1'b1, 32'h55AA55AA, 2, 1'b0, 0); // R2 type0 on bus1
        run(8'd0, 5'd0, 3'd0, 12'h004, 1'b0, 0, 1, 1'b0, 32'h0BAD0000); // R3 target unchanged
        run(8'd2, 5'd31, 3'd7, 12'h102, 1'b0, 0, 3, 1'b1, 32'h12345678); // R6 faulted read
        run(8'd255, 5'd17, 3'd3, 12'h0FC, 1'b1, 32'hDEADBEEF, 0, 1'b1, 0); // R6 faulted write
        run(8'd0, 5'd31, 3'd7, 12'h000, 1'b0, 0, 0, 1'b0, 0);           // R1 reject after programmed
        // constrained random
        for (int k = 0; k < 300; k++) begin
            logic [7:0] b;
            int sel;
            sel = $urandom_range(0, 3);
            b = (sel == 0) ? 8'd0 : (sel == 1) ? 8'd1 : 8'($urandom_range(2, 255));
            run(b, 5'($urandom_range(0, 3) == 0 ? $urandom_range(0, 31) : $urandom_range(0, 1)),
                3'($urandom_range(0, 7)), 12'($urandom_range(0, 4095)), 1'($urandom_range(0, 1)),
                $urandom(), $urandom_range(0, 3), ($urandom_range(0, 4) == 0), $urandom());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule